// File: doc/BRIEF.md
# Accumulator CPU Multicycle Controller

A 16-bit accumulator machine whose control sequencer walks every instruction through fetch, decode and execute, spending exactly one clock in each register-transfer step. The sequencer emits one micro-operation per cycle to a datapath that holds the accumulator, memory address and buffer registers, program counter, instruction register and the input and output latches. A single-port word-addressed RAM sits outside the block; its read data is used in the same cycle as the address, and a write commits on the clock edge while the write strobe is high.

On top of the basic set (load, store, add, input, output, halt, jump, the indirect forms of add, jump and store) the machine provides subtraction, a jump-and-save subroutine call, an indirect load, an unsigned 12-bit immediate load, and a conditional skip. The skip decides from zero and negative indicators that the datapath derives from the accumulator and passes to the sequencer.

Top module: `acc_cpu_core`

## Requirements
- R1: While rst_ni is low, mem_addr_o is 0, mem_we_o is 0, out_data_o is 0 and halted_o is 0; the reset is asynchronous and execution restarts from address 0.
- R2: An instruction word carries the opcode in bits 15:12 and an operand X in bits 11:0; opcodes are 0 jump-and-save, 1 load, 2 store, 3 add, 4 subtract, 5 input, 6 output, 7 halt, 8 skip, 9 jump, A immediate load, B indirect add, C indirect jump, D indirect load, E indirect store. Load sets AC to M[X], store writes AC to M[X], add sets AC to AC+M[X] modulo 2^16, jump sets PC to X.
- R3: Subtract sets AC to AC minus M[X] modulo 2^16.
- R4: Jump-and-save X writes the address following the call into M[X], then continues at X+1; AC is left holding X+1.
- R5: Indirect load sets AC to M[M[X]].
- R6: Immediate load (opcode A) sets AC to X zero-extended to 16 bits, whatever AC held before.
- R7: Skip (opcode 8) tests bits 11:10 of its word: 00 skips the next instruction when AC is negative, 01 when AC is zero, 10 when AC is greater than zero, 11 never skips; bits 9:0 have no effect.
- R8: Indirect add sets AC to AC+M[M[X]], indirect store writes AC to M[M[X]], indirect jump sets PC to M[X].
- R9: Input copies in_data_i into AC; output copies AC to out_data_o, which then holds its value until the next output instruction.
- R10: After halt, halted_o stays high, the memory address stays put and no memory write occurs until reset.
- R11: Every memory write lasts exactly one cycle and two writes are never in adjacent cycles.
- R12: From reset release, fetch and decode take 5 cycles, after which halted_o is high for a halt; execution takes 3 further cycles for load, store, add, subtract and indirect jump, 1 for output, 5 for indirect load, add and store, and 6 for jump-and-save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_rdata_i | input | 16 | Word read from RAM at mem_addr_o, same cycle |
| in_data_i | input | 16 | Value captured by the input instruction |
| mem_addr_o | output | 12 | RAM word address (memory address register) |
| mem_wdata_o | output | 16 | Write data (memory buffer register) |
| mem_we_o | output | 1 | Write strobe, write commits on the rising edge |
| out_data_o | output | 16 | Output latch |
| halted_o | output | 1 | High once a halt instruction has been reached |

## Verification
The bench builds the core with its default word and address widths and reset address 0, attached to a 256-word RAM model, which keeps every program, operand and pointer within addresses the bench can preload and inspect. That configuration makes it cheap to sweep arithmetic over sign and carry boundary operands, every pair of skip selector and accumulator sign, immediates across the whole 12-bit range, and call targets at several distances. Final memory words, the output latch and the cycle count to halt are predicted arithmetically from the program each run loads.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned OPC_W  = 4;
  localparam int unsigned ADDR_W = DATA_W - OPC_W;

  typedef enum logic [OPC_W-1:0] {
    OP_JNS    = 4'h0, OP_LOAD   = 4'h1, OP_STORE  = 4'h2, OP_ADD    = 4'h3,
    OP_SUBT   = 4'h4, OP_INPUT  = 4'h5, OP_OUTPUT = 4'h6, OP_HALT   = 4'h7,
    OP_SKIP   = 4'h8, OP_JUMP   = 4'h9, OP_IMM    = 4'hA, OP_ADDI   = 4'hB,
    OP_JUMPI  = 4'hC, OP_LOADI  = 4'hD, OP_STOREI = 4'hE, OP_RSVD   = 4'hF
  } opcode_e;

  typedef enum logic [4:0] {
    UOP_NOP, UOP_MAR_PC, UOP_MBR_MEM, UOP_IR_MBR, UOP_PC_INC, UOP_MAR_IR,
    UOP_MAR_MBR, UOP_MBR_AC, UOP_MBR_PC, UOP_MBR_IR, UOP_AC_MBR, UOP_AC_ADD,
    UOP_AC_SUB, UOP_AC_INC, UOP_AC_IMM, UOP_AC_IN, UOP_IN_LATCH, UOP_OUT_AC,
    UOP_MEM_WR, UOP_PC_IR, UOP_PC_MBR, UOP_PC_AC
  } uop_e;

  typedef enum logic [1:0] {ALU_PASS, ALU_ADD, ALU_SUB, ALU_INC} alu_op_e;

  typedef struct packed {
    logic zero;
    logic neg;
  } flags_t;

  typedef enum logic [4:0] {
    S_FMAR, S_FMBR, S_FIR, S_FPC, S_DEC,
    S_OPA, S_OPM, S_IMAR, S_IMBR,
    S_LD_AC, S_ADD, S_SUB, S_ST_MBR, S_ST_WR,
    S_IN_LATCH, S_IN_AC, S_OUT, S_HALT, S_SKIP, S_JUMP, S_IMM, S_JI_PC,
    S_JNS_MBR, S_JNS_MAR, S_JNS_WR, S_JNS_MBR2, S_JNS_AC, S_JNS_PC
  } state_e;

  localparam logic [1:0] SKIP_NEG  = 2'b00;
  localparam logic [1:0] SKIP_ZERO = 2'b01;
  localparam logic [1:0] SKIP_POS  = 2'b10;
endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_INC: y_o = b_i + W'(1);
      default: y_o = b_i;
    endcase
  end
endmodule

// File: rtl/acc_cpu_dpath.sv
module acc_cpu_dpath
  import acc_cpu_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  uop_e              uop_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [DATA_W-1:0] out_data_o,
  output opcode_e           opcode_o,
  output logic [1:0]        cond_o,
  output logic [ADDR_W-1:0] pc_o,
  output flags_t            flags_o
);
  logic [DATA_W-1:0] ac_q, mbr_q, ir_q, in_q, out_q;
  logic [ADDR_W-1:0] mar_q, pc_q;
  logic [DATA_W-1:0] alu_y;
  alu_op_e           alu_op;

  always_comb begin
    unique case (uop_i)
      UOP_AC_ADD: alu_op = ALU_ADD;
      UOP_AC_SUB: alu_op = ALU_SUB;
      UOP_AC_INC: alu_op = ALU_INC;
      default:    alu_op = ALU_PASS;
    endcase
  end

  acc_cpu_alu #(.W(DATA_W)) u_alu (
    .op_i(alu_op), .a_i(ac_q), .b_i(mbr_q), .y_o(alu_y)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_q  <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
      in_q  <= '0;
      out_q <= '0;
      mar_q <= RESET_PC;
      pc_q  <= RESET_PC;
    end else begin
      unique case (uop_i)
        UOP_MAR_PC:   mar_q <= pc_q;
        UOP_MBR_MEM:  mbr_q <= mem_rdata_i;
        UOP_IR_MBR:   ir_q  <= mbr_q;
        UOP_PC_INC:   pc_q  <= pc_q + ADDR_W'(1);
        UOP_MAR_IR:   mar_q <= ir_q[ADDR_W-1:0];
        UOP_MAR_MBR:  mar_q <= mbr_q[ADDR_W-1:0];
        UOP_MBR_AC:   mbr_q <= ac_q;
        UOP_MBR_PC:   mbr_q <= DATA_W'(pc_q);
        UOP_MBR_IR:   mbr_q <= DATA_W'(ir_q[ADDR_W-1:0]);
        UOP_AC_MBR,
        UOP_AC_ADD,
        UOP_AC_SUB,
        UOP_AC_INC:   ac_q  <= alu_y;
        UOP_AC_IMM:   ac_q  <= DATA_W'(ir_q[ADDR_W-1:0]);
        UOP_AC_IN:    ac_q  <= in_q;
        UOP_IN_LATCH: in_q  <= in_data_i;
        UOP_OUT_AC:   out_q <= ac_q;
        UOP_PC_IR:    pc_q  <= ir_q[ADDR_W-1:0];
        UOP_PC_MBR:   pc_q  <= mbr_q[ADDR_W-1:0];
        UOP_PC_AC:    pc_q  <= ac_q[ADDR_W-1:0];
        default: ;
      endcase
    end
  end

  assign mem_addr_o   = mar_q;
  assign mem_wdata_o  = mbr_q;
  assign out_data_o   = out_q;
  assign opcode_o     = opcode_e'(ir_q[DATA_W-1:ADDR_W]);
  assign cond_o       = ir_q[ADDR_W-1:ADDR_W-2];
  assign pc_o         = pc_q;
  assign flags_o.zero = (ac_q == '0);
  assign flags_o.neg  = ac_q[DATA_W-1];
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  opcode_e    opcode_i,
  input  logic [1:0] cond_i,
  input  flags_t     flags_i,
  output uop_e       uop_o,
  output state_e     state_o,
  output logic       mem_we_o,
  output logic       halted_o
);
  state_e state_q, state_d;
  logic   skip_take;

  always_comb begin
    unique case (cond_i)
      SKIP_NEG:  skip_take = flags_i.neg;
      SKIP_ZERO: skip_take = flags_i.zero;
      SKIP_POS:  skip_take = !flags_i.neg && !flags_i.zero;
      default:   skip_take = 1'b0;
    endcase
  end

  always_comb begin
    state_d = S_FMAR;
    unique case (state_q)
      S_FMAR: state_d = S_FMBR;
      S_FMBR: state_d = S_FIR;
      S_FIR:  state_d = S_FPC;
      S_FPC:  state_d = S_DEC;
      S_DEC: begin
        unique case (opcode_i)
          OP_JNS:    state_d = S_JNS_MBR;
          OP_LOAD, OP_STORE, OP_ADD, OP_SUBT,
          OP_ADDI, OP_JUMPI, OP_LOADI, OP_STOREI:
                     state_d = S_OPA;
          OP_INPUT:  state_d = S_IN_LATCH;
          OP_OUTPUT: state_d = S_OUT;
          OP_HALT:   state_d = S_HALT;
          OP_SKIP:   state_d = S_SKIP;
          OP_JUMP:   state_d = S_JUMP;
          OP_IMM:    state_d = S_IMM;
          default:   state_d = S_FMAR;
        endcase
      end
      S_OPA: state_d = (opcode_i == OP_STORE) ? S_ST_MBR : S_OPM;
      S_OPM: begin
        unique case (opcode_i)
          OP_LOAD:  state_d = S_LD_AC;
          OP_ADD:   state_d = S_ADD;
          OP_SUBT:  state_d = S_SUB;
          OP_JUMPI: state_d = S_JI_PC;
          default:  state_d = S_IMAR;
        endcase
      end
      S_IMAR:     state_d = (opcode_i == OP_STOREI) ? S_ST_MBR : S_IMBR;
      S_IMBR:     state_d = (opcode_i == OP_LOADI) ? S_LD_AC : S_ADD;
      S_ST_MBR:   state_d = S_ST_WR;
      S_IN_LATCH: state_d = S_IN_AC;
      S_HALT:     state_d = S_HALT;
      S_JNS_MBR:  state_d = S_JNS_MAR;
      S_JNS_MAR:  state_d = S_JNS_WR;
      S_JNS_WR:   state_d = S_JNS_MBR2;
      S_JNS_MBR2: state_d = S_JNS_AC;
      S_JNS_AC:   state_d = S_JNS_PC;
      default:    state_d = S_FMAR;
    endcase
  end

  always_comb begin
    unique case (state_q)
      S_FMAR:     uop_o = UOP_MAR_PC;
      S_FMBR:     uop_o = UOP_MBR_MEM;
      S_FIR:      uop_o = UOP_IR_MBR;
      S_FPC:      uop_o = UOP_PC_INC;
      S_OPA:      uop_o = UOP_MAR_IR;
      S_OPM:      uop_o = UOP_MBR_MEM;
      S_IMAR:     uop_o = UOP_MAR_MBR;
      S_IMBR:     uop_o = UOP_MBR_MEM;
      S_LD_AC:    uop_o = UOP_AC_MBR;
      S_ADD:      uop_o = UOP_AC_ADD;
      S_SUB:      uop_o = UOP_AC_SUB;
      S_ST_MBR:   uop_o = UOP_MBR_AC;
      S_ST_WR:    uop_o = UOP_MEM_WR;
      S_IN_LATCH: uop_o = UOP_IN_LATCH;
      S_IN_AC:    uop_o = UOP_AC_IN;
      S_OUT:      uop_o = UOP_OUT_AC;
      S_SKIP:     uop_o = skip_take ? UOP_PC_INC : UOP_NOP;
      S_JUMP:     uop_o = UOP_PC_IR;
      S_IMM:      uop_o = UOP_AC_IMM;
      S_JI_PC:    uop_o = UOP_PC_MBR;
      S_JNS_MBR:  uop_o = UOP_MBR_PC;
      S_JNS_MAR:  uop_o = UOP_MAR_IR;
      S_JNS_WR:   uop_o = UOP_MEM_WR;
      S_JNS_MBR2: uop_o = UOP_MBR_IR;
      S_JNS_AC:   uop_o = UOP_AC_INC;
      S_JNS_PC:   uop_o = UOP_PC_AC;
      default:    uop_o = UOP_NOP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_FMAR;
    else         state_q <= state_d;
  end

  assign state_o  = state_q;
  assign mem_we_o = (uop_o == UOP_MEM_WR);
  assign halted_o = (state_q == S_HALT);
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              halted_o
);
  uop_e              uop_w;
  state_e            state_w;
  opcode_e           opcode_w;
  logic [1:0]        cond_w;
  flags_t            flags_w;
  logic [ADDR_W-1:0] pc_w;

  acc_cpu_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opcode_i (opcode_w),
    .cond_i   (cond_w),
    .flags_i  (flags_w),
    .uop_o    (uop_w),
    .state_o  (state_w),
    .mem_we_o (mem_we_o),
    .halted_o (halted_o)
  );

  acc_cpu_dpath #(.RESET_PC(RESET_PC)) u_dpath (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .uop_i       (uop_w),
    .mem_rdata_i (mem_rdata_i),
    .in_data_i   (in_data_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .out_data_o  (out_data_o),
    .opcode_o    (opcode_w),
    .cond_o      (cond_w),
    .pc_o        (pc_w),
    .flags_o     (flags_w)
  );
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              halted_i,
  input logic              mem_we_i,
  input logic [DATA_W-1:0] out_data_i,
  input uop_e              uop_i,
  input state_e            state_i,
  input logic [1:0]        cond_i,
  input flags_t            flags_i,
  input logic [ADDR_W-1:0] pc_i
);
  assert_halt_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> halted_i);

  assert_halt_no_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |-> !mem_we_i);

  assert_write_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |=> !mem_we_i);

  assert_out_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_i != UOP_OUT_AC) |=> $stable(out_data_i));

  assert_skip_zero_taken_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_SKIP && cond_i == 2'b01 && flags_i.zero) |=> (pc_i == $past(pc_i) + 1'b1));

  assert_skip_never_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_SKIP && cond_i == 2'b11) |=> $stable(pc_i));
endmodule

bind acc_cpu_core acc_cpu_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .halted_i   (halted_o),
  .mem_we_i   (mem_we_o),
  .out_data_i (out_data_o),
  .uop_i      (uop_w),
  .state_i    (state_w),
  .cond_i     (cond_w),
  .flags_i    (flags_w),
  .pc_i       (pc_w)
);

// File: tb/acc_cpu_core_test.sv
module acc_cpu_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_LIMIT  = 2000;

  localparam logic [3:0] O_JNS = 4'h0, O_LOAD = 4'h1, O_STORE = 4'h2, O_ADD = 4'h3,
                         O_SUBT = 4'h4, O_INPUT = 4'h5, O_OUTPUT = 4'h6, O_HALT = 4'h7,
                         O_SKIP = 4'h8, O_JUMP = 4'h9, O_IMM = 4'hA, O_ADDI = 4'hB,
                         O_JUMPI = 4'hC, O_LOADI = 4'hD, O_STOREI = 4'hE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] in_data = '0;
  logic [15:0] mem_rdata, mem_wdata, out_data;
  logic [11:0] mem_addr;
  logic        mem_we, halted;
  logic [15:0] mem [0:255];

  int tests = 0;
  int fails = 0;
  int bb_viol = 0;
  int wr_cnt = 0;
  logic prev_we = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu_core uut (
    .clk_i(clk), .rst_ni(rst_n), .mem_rdata_i(mem_rdata), .in_data_i(in_data),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
    .out_data_o(out_data), .halted_o(halted)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
    if (rst_n) begin
      if (mem_we && prev_we) bb_viol++;
      if (mem_we) wr_cnt++;
      prev_we = mem_we;
    end else begin
      prev_we = 1'b0;
    end
  end

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] x);
    return {op, x};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic prep();
    rst_n = 1'b0;
    #1;
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  task automatic run_prog(output int cyc);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < RUN_LIMIT) begin
      @(negedge clk);
      cyc++;
    end
    if (!halted) chk("R10 program did not halt", 0, 1);
  endtask

  logic [15:0] vals [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cyc;
    // R1: reset state
    prep();
    repeat (3) @(negedge clk);
    chk("R1 addr", mem_addr, 0);
    chk("R1 we", mem_we, 0);
    chk("R1 out", out_data, 0);
    chk("R1 halted", halted, 0);

    // R10 / R12: halt only, then a store that must never run
    prep();
    mem[0]  = ins(O_HALT, 12'h0);
    mem[1]  = ins(O_STORE, 12'd30);
    mem[30] = 16'h1234;
    run_prog(cyc);
    chk("R12 halt cycles", cyc, 5);
    repeat (20) @(negedge clk);
    chk("R10 stays halted", halted, 1);
    chk("R10 no write", mem[30], 16'h1234);
    chk("R10 addr held", mem_addr, 0);

    // R2 / R3 / R12: add and subtract sweeps
    for (int sub = 0; sub < 2; sub++) begin
      for (int i = 0; i < 6; i++) begin
        for (int j = 0; j < 6; j++) begin
          logic [15:0] expv;
          prep();
          mem[0]  = ins(O_LOAD, 12'd40);
          mem[1]  = ins(sub != 0 ? O_SUBT : O_ADD, 12'd41);
          mem[2]  = ins(O_STORE, 12'd42);
          mem[3]  = ins(O_HALT, 12'h0);
          mem[40] = vals[i];
          mem[41] = vals[j];
          run_prog(cyc);
          expv = (sub != 0) ? vals[i] - vals[j] : vals[i] + vals[j];
          chk(sub != 0 ? "R3 subtract" : "R2 load/add/store", mem[42], expv);
          chk("R12 three-op cycles", cyc, 29);
        end
      end
    end

    // R4: jump-and-save at several targets
    for (int t = 0; t < 3; t++) begin
      logic [11:0] x;
      x = (t == 0) ? 12'd50 : (t == 1) ? 12'd100 : 12'd200;
      prep();
      mem[0]   = ins(O_JNS, x);
      mem[1]   = ins(O_STORE, 12'd60);
      mem[2]   = ins(O_HALT, 12'h0);
      mem[x+1] = ins(O_OUTPUT, 12'h0);
      mem[x+2] = ins(O_JUMPI, x);
      run_prog(cyc);
      chk("R4 return address saved", mem[x[7:0]], 16'd1);
      chk("R4 AC and entry X+1", out_data, {4'h0, x} + 16'd1);
      chk("R4 return path", mem[60], {4'h0, x} + 16'd1);
      chk("R12 call cycles", cyc, 38);
    end

    // R5: indirect load
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 6; i++) begin
        logic [7:0] ptr;
        ptr = (p == 0) ? 8'd80 : (p == 1) ? 8'd150 : 8'd255;
        prep();
        mem[0]   = ins(O_LOADI, 12'd70);
        mem[1]   = ins(O_STORE, 12'd71);
        mem[2]   = ins(O_HALT, 12'h0);
        mem[70]  = {8'h00, ptr};
        mem[ptr] = vals[i];
        run_prog(cyc);
        chk("R5 indirect load", mem[71], vals[i]);
        chk("R12 indirect load cycles", cyc, 23);
      end
    end

    // R6: immediate load across the 12-bit range, AC preset to all ones
    for (int i = 0; i < 42; i++) begin
      logic [11:0] v;
      v = (i == 40) ? 12'hFFF : (i == 41) ? 12'h800 : 12'(i * 103);
      prep();
      mem[0]  = ins(O_LOAD, 12'd90);
      mem[1]  = ins(O_IMM, v);
      mem[2]  = ins(O_STORE, 12'd91);
      mem[3]  = ins(O_HALT, 12'h0);
      mem[90] = 16'hFFFF;
      run_prog(cyc);
      chk("R6 immediate zero-extend", mem[91], {4'h0, v});
    end

    // R7: every selector against every accumulator sign
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < 5; k++) begin
        logic [15:0] a;
        logic        take;
        a = (k == 0) ? 16'hFFFB : (k == 1) ? 16'h0000 : (k == 2) ? 16'h0007 :
            (k == 3) ? 16'h8000 : 16'h0001;
        take = (c == 0 && a[15]) || (c == 1 && a == 0) || (c == 2 && !a[15] && a != 0);
        prep();
        mem[0]  = ins(O_LOAD, 12'd20);
        mem[1]  = ins(O_SKIP, {2'(c), 10'h155});
        mem[2]  = ins(O_IMM, 12'hABC);
        mem[3]  = ins(O_STORE, 12'd21);
        mem[4]  = ins(O_HALT, 12'h0);
        mem[20] = a;
        run_prog(cyc);
        chk("R7 skip decision", mem[21], take ? a : 16'h0ABC);
      end
    end

    // R8 / R2: indirect add, indirect store, indirect jump, direct jump
    for (int i = 0; i < 6; i++) begin
      logic [15:0] b, s;
      b = vals[(i + 2) % 6];
      s = vals[i] + b;
      prep();
      mem[0]   = ins(O_LOAD, 12'd100);
      mem[1]   = ins(O_ADDI, 12'd101);
      mem[2]   = ins(O_STOREI, 12'd103);
      mem[3]   = ins(O_JUMPI, 12'd105);
      mem[4]   = ins(O_HALT, 12'h0);
      mem[7]   = ins(O_STORE, 12'd106);
      mem[8]   = ins(O_JUMP, 12'd12);
      mem[9]   = ins(O_HALT, 12'h0);
      mem[12]  = ins(O_STORE, 12'd107);
      mem[13]  = ins(O_HALT, 12'h0);
      mem[100] = vals[i];
      mem[101] = 16'd102;
      mem[102] = b;
      mem[103] = 16'd104;
      mem[105] = 16'd7;
      run_prog(cyc);
      chk("R8 indirect add/store", mem[104], s);
      chk("R8 indirect jump", mem[106], s);
      chk("R2 direct jump", mem[107], s);
    end

    // R9: input and output, output held afterwards
    for (int i = 0; i < 6; i++) begin
      prep();
      in_data = vals[i];
      mem[0]  = ins(O_INPUT, 12'h0);
      mem[1]  = ins(O_OUTPUT, 12'h0);
      mem[2]  = ins(O_STORE, 12'd110);
      mem[3]  = ins(O_HALT, 12'h0);
      run_prog(cyc);
      in_data = ~vals[i];
      repeat (5) @(negedge clk);
      chk("R9 input to AC", mem[110], vals[i]);
      chk("R9 output held", out_data, vals[i]);
    end

    // R1: asynchronous reset clears the output latch
    rst_n = 1'b0;
    #1;
    chk("R1 async out clear", out_data, 0);
    chk("R1 async halted clear", halted, 0);

    // R11: write strobe monitor
    chk("R11 no adjacent writes", bb_viol, 0);
    chk("R11 writes observed", (wr_cnt > 0) ? 1 : 0, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule